// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Bus Interface

This block is the digital side of a multichannel converter that samples all of its channels at the same moment. A host uses one shared 16-line bidirectional bus and three active-low strobes to operate it. The chip select and write strobes load a 4-bit setup word from the lowest four bus lines. The chip select and read strobes return one 16-bit channel result for each read strobe. A convert trigger input starts a conversion, and a busy flag shows when results are ready.

The analog front end and the converter core are not modelled. When a conversion starts, the block captures one 16-bit offset-binary word per channel from a flat sample port. The conversion time is a fixed number of clock cycles set by a parameter. Two acquisition modes are available. In trigger-gated mode the trigger must be held low for a minimum acquisition window before its rising edge is accepted. In free-running mode acquisition is always considered complete once the previous conversion has ended, so any rising edge is accepted. The block can also return results in two's complement form.

All strobe inputs are treated as synchronous to `clk`. An edge on a strobe takes effect at the first clock edge that sees the new level.

Top module: `ssadc_bus_if`

## Requirements
- R1: After reset the setup word is 0000, `eoc` is high, the read pointer is at channel 0 and every stored result is 0x0000.
- R2: The setup word is loaded from `data_io[3:0]` at the clock edge that first sees `wr_n` high after it was low, provided `cs_n` is low at that edge. A `wr_n` rising edge seen while `cs_n` is high leaves the setup word unchanged. Bit layout of the setup word: bit 3 is the reference select (stored only), bit 2 is the result format, bit 1 is spare, bit 0 is the acquisition mode.
- R3: When setup bit 2 is 1, each result is returned with its bit 15 inverted (two's complement). When bit 2 is 0, the stored offset-binary word is returned unchanged.
- R4: With setup bit 0 equal to 0, a rising edge of `conv_trig` starts a conversion only if `conv_trig` was seen low at ACQ_MIN_CYCLES or more consecutive clock edges just before it. A shorter low pulse is ignored: `eoc` and the stored results do not change.
- R5: With setup bit 0 equal to 1, any rising edge of `conv_trig` starts a conversion while none is in progress, however short the preceding low time.
- R6: `eoc` goes high at the clock edge that accepts a conversion start. It goes low exactly CONV_CYCLES clock edges later.
- R7: All channels are captured from `sample_in` at the start edge. Channel k occupies bits [16k+15:16k]. Later changes of `sample_in` do not alter the results.
- R8: A rising edge of `conv_trig` while `eoc` is high is ignored. It neither restarts the count nor re-captures the samples.
- R9: While `cs_n` and `rd_n` are both low, `data_io` carries the result of the channel under the read pointer. The pointer advances when `rd_n` rises with `cs_n` low and wraps from NUM_CH-1 to 0. It returns to 0 on every conversion start. A `rd_n` pulse with `cs_n` high does not move it.
- R10: The block leaves all 16 lines of `data_io` undriven whenever `cs_n` or `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe; each low period returns one channel |
| wr_n | input | 1 | Active-low write strobe; the setup word is taken on its rising edge |
| conv_trig | input | 1 | Convert trigger; its rising edge starts a conversion |
| sample_in | input | NUM_CH*16 | Offset-binary sample of every channel, channel 0 in the low bits |
| eoc | output | 1 | High while a conversion runs; low when results are ready |
| data_io | inout | 16 | Shared bus: setup word in on bits 3..0, results out on all bits |

## Verification
A read pointer that is off by one shows up at the very next read strobe, because the returned word belongs to the wrong channel. The bench therefore tracks the pointer itself through wraps, ignored strobes and conversion restarts. An acquisition counter or conversion counter in the wrong state moves the falling edge of `eoc` away from its fixed cycle, or lets a short trigger pulse start a conversion. The bench samples `eoc` one cycle before and at its expected fall. It also re-reads data after every ignored trigger, so a spurious capture is exposed on the first read. A stale setup word appears as a wrong bit 15 on the first result read after the write.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned CFG_W  = 4;

  // setup word; bit positions are decoded from the bus, so order matters
  typedef struct packed {
    logic ext_ref;    // bit 3: reference select, stored only
    logic twos_fmt;   // bit 2: result format
    logic spare;      // bit 1: unused
    logic auto_acq;   // bit 0: acquisition mode
  } cfg_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_t;

endpackage

// File: rtl/ssadc_cfg_reg.sv
module ssadc_cfg_reg
  import ssadc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [CFG_W-1:0] bus_lo,
  output cfg_t             cfg
);

  logic wr_q;
  logic wr_rise;
  logic cfg_en;
  cfg_t cfg_d;

  always_comb begin
    wr_rise = wr_n && !wr_q;
    cfg_en  = wr_rise && !cs_n;
    cfg_d   = cfg_en ? cfg_t'(bus_lo) : cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      cfg  <= '0;
    end else begin
      wr_q <= wr_n;
      if (cfg_en) begin
        cfg <= cfg_d;
      end
    end
  end

  // R2: without a selected write edge the setup word holds
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && wr_n && !wr_q) |=> $stable(cfg));

endmodule

// File: rtl/ssadc_conv_seq.sv
module ssadc_conv_seq
  import ssadc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES    = 20,
  parameter int unsigned ACQ_MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_trig,
  input  logic auto_acq,
  output logic start,
  output logic eoc
);

  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
  localparam int unsigned AW = $clog2(ACQ_MIN_CYCLES + 1);

  seq_state_t    state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic [AW-1:0] acq_cnt, acq_d;
  logic          eoc_d;
  logic          trig_q;
  logic          trig_rise;
  logic          acq_ok;

  always_comb begin
    trig_rise = conv_trig && !trig_q;
    acq_ok    = auto_acq || (acq_cnt >= AW'(ACQ_MIN_CYCLES));
    start     = (state == SEQ_IDLE) && trig_rise && acq_ok;

    state_d = state;
    cnt_d   = cnt;
    eoc_d   = eoc;
    unique case (state)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_CONV;
          cnt_d   = CW'(CONV_CYCLES - 1);
          eoc_d   = 1'b1;
        end
      end
      SEQ_CONV: begin
        if (cnt == '0) begin
          state_d = SEQ_IDLE;
          eoc_d   = 1'b0;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase

    // acquisition window: consecutive low edges outside a conversion
    if ((state == SEQ_CONV) || conv_trig) begin
      acq_d = '0;
    end else if (acq_cnt != AW'(ACQ_MIN_CYCLES)) begin
      acq_d = acq_cnt + 1'b1;
    end else begin
      acq_d = acq_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      acq_cnt <= '0;
      eoc     <= 1'b1;
      trig_q  <= 1'b1;
    end else begin
      state   <= state_d;
      cnt     <= cnt_d;
      acq_cnt <= acq_d;
      eoc     <= eoc_d;
      trig_q  <= conv_trig;
    end
  end

  // R6: busy flag is high for the whole conversion
  a_r6_busy_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_CONV) |-> eoc);

  // R6: the busy flag only falls at the end of a conversion
  a_r6_fall_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> ($past(state) == SEQ_CONV));

  // R6: count stays inside its window
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_CONV) |-> (cnt < CW'(CONV_CYCLES)));

  // R8: a conversion in progress keeps running to its end
  a_r8_conv_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_CONV && cnt != '0) |=> (state == SEQ_CONV));

endmodule

// File: rtl/ssadc_result_bank.sv
module ssadc_result_bank
  import ssadc_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     twos_fmt,
  input  logic [NUM_CH*WORD_W-1:0] sample_in,
  output logic [WORD_W-1:0]        rd_word
);

  localparam int unsigned PW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [PW-1:0] LAST_CH = PW'(NUM_CH - 1);

  logic [WORD_W-1:0] bank_view [NUM_CH];
  logic [PW-1:0]     ptr, ptr_d;
  logic              rd_q;
  logic              rd_rise;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (start) begin
        word_q <= sample_in[ch*WORD_W +: WORD_W];
      end
    end
    assign bank_view[ch] = word_q;
  end

  always_comb begin
    rd_rise = rd_n && !rd_q;
    if (start) begin
      ptr_d = '0;
    end else if (rd_rise && !cs_n) begin
      ptr_d = (ptr == LAST_CH) ? '0 : ptr + 1'b1;
    end else begin
      ptr_d = ptr;
    end
    rd_word = bank_view[ptr] ^ {twos_fmt, {(WORD_W-1){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      rd_q <= 1'b1;
    end else begin
      ptr  <= ptr_d;
      rd_q <= rd_n;
    end
  end

  // R9: pointer never leaves the channel range
  a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST_CH);

  // R9: a conversion start rewinds the pointer
  a_r9_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ptr == '0));

  // R9: unselected strobes do not move the pointer
  a_r9_ptr_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !start) |=> $stable(ptr));

endmodule

// File: rtl/ssadc_bus_if.sv
module ssadc_bus_if
  import ssadc_pkg::*;
#(
  parameter int unsigned NUM_CH         = 8,
  parameter int unsigned CONV_CYCLES    = 20,
  parameter int unsigned ACQ_MIN_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic                     conv_trig,
  input  logic [NUM_CH*WORD_W-1:0] sample_in,
  output logic                     eoc,
  inout  wire  [WORD_W-1:0]        data_io
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  cfg_t              cfg;
  logic              start;
  logic [WORD_W-1:0] rd_word;
  logic              drive_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  ssadc_cfg_reg i_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .bus_lo (data_io[CFG_W-1:0]),
    .cfg    (cfg)
  );

  ssadc_conv_seq #(
    .CONV_CYCLES    (CONV_CYCLES),
    .ACQ_MIN_CYCLES (ACQ_MIN_CYCLES)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .conv_trig (conv_trig),
    .auto_acq  (cfg.auto_acq),
    .start     (start),
    .eoc       (eoc)
  );

  ssadc_result_bank #(
    .NUM_CH (NUM_CH)
  ) i_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .twos_fmt  (cfg.twos_fmt),
    .sample_in (sample_in),
    .rd_word   (rd_word)
  );

  assign drive_en = !cs_n && !rd_n;
  assign data_io  = drive_en ? rd_word : {WORD_W{1'bz}};

  // R6: an accepted start raises the busy flag on the next cycle
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> eoc);

  // R8: no start is accepted while a conversion is running
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eoc && $past(start)) |-> !start);

endmodule

// File: tb/test_ssadc_bus_if.sv
module test_ssadc_bus_if;

  localparam int NCH  = 8;
  localparam int CONV = 20;
  localparam int AMIN = 4;

  logic              clk;
  logic              rst_n;
  logic              cs_n;
  logic              rd_n;
  logic              wr_n;
  logic              conv_trig;
  logic [NCH*16-1:0] sample_in;
  logic              eoc;
  wire  [15:0]       data_io;
  logic [15:0]       tb_drv;
  logic              tb_drv_en;

  int n_chk;
  int n_fail;
  bit finished;

  logic [15:0] exp_bank [NCH];
  int          exp_ptr;
  logic        exp_fmt;

  assign data_io = tb_drv_en ? tb_drv : {16{1'bz}};

  ssadc_bus_if #(
    .NUM_CH         (NCH),
    .CONV_CYCLES    (CONV),
    .ACQ_MIN_CYCLES (AMIN)
  ) i_ssadc_bus_if (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .conv_trig (conv_trig),
    .sample_in (sample_in),
    .eoc       (eoc),
    .data_io   (data_io)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] smp(input int seed, input int ch);
    return 16'((seed * 16'h1357) ^ (ch * 16'h0F1D) ^ (ch << 13));
  endfunction

  task automatic load_samples(input int seed);
    for (int ch = 0; ch < NCH; ch++) sample_in[ch*16 +: 16] = smp(seed, ch);
  endtask

  // the bench's own idea of a capture
  task automatic model_capture(input int seed);
    for (int ch = 0; ch < NCH; ch++) exp_bank[ch] = smp(seed, ch);
    exp_ptr = 0;
  endtask

  task automatic write_cfg(input logic [3:0] val, input logic sel_n);
    cs_n = sel_n; wr_n = 1'b0; tb_drv = {12'h000, val}; tb_drv_en = 1'b1;
    tick(1);
    wr_n = 1'b1;
    tick(1);
    cs_n = 1'b1; tb_drv_en = 1'b0;
    tick(1);
  endtask

  task automatic read_chk(input string req, input bit keep_cs);
    logic [15:0] e;
    cs_n = 1'b0; rd_n = 1'b0;
    tick(1);
    e = exp_bank[exp_ptr] ^ {exp_fmt, 15'h0};
    chk(req, $sformatf("read ch%0d", exp_ptr), data_io, e);
    rd_n = 1'b1;
    tick(1);
    if (!keep_cs) cs_n = 1'b1;
    exp_ptr = (exp_ptr == NCH - 1) ? 0 : exp_ptr + 1;
  endtask

  // low pulse on the trigger, then the rising edge
  task automatic trig_pulse(input int low_len);
    conv_trig = 1'b0;
    tick(low_len);
    conv_trig = 1'b1;
  endtask

  task automatic eoc_timing(input string req, input int already);
    tick(CONV - already);
    chk(req, "eoc one edge before end", {15'h0, eoc}, 16'h0001);
    tick(1);
    chk(req, "eoc at end", {15'h0, eoc}, 16'h0000);
  endtask

  task automatic t_reset;
    chk("R1", "eoc after reset", {15'h0, eoc}, 16'h0001);
    read_chk("R1", 1'b0);
  endtask

  task automatic t_mode0_conv;
    load_samples(1);
    trig_pulse(AMIN + 2);
    model_capture(1);
    tick(1);
    chk("R6", "eoc at start", {15'h0, eoc}, 16'h0001);
    eoc_timing("R6", 1);
    load_samples(9);  // R7: later input change must not matter
    for (int k = 0; k < NCH; k++) read_chk("R7", 1'b1);
    read_chk("R9", 1'b0);  // wraps to channel 0
  endtask

  task automatic t_format;
    write_cfg(4'b0100, 1'b0);
    exp_fmt = 1'b1;
    read_chk("R3", 1'b0);
    read_chk("R2", 1'b0);
  endtask

  task automatic t_short_mode0;
    load_samples(2);
    trig_pulse(AMIN - 2);
    tick(CONV + 5);
    chk("R4", "eoc after short pulse", {15'h0, eoc}, 16'h0000);
    read_chk("R4", 1'b0);
  endtask

  task automatic t_mode1;
    write_cfg(4'b0001, 1'b0);
    exp_fmt = 1'b0;
    trig_pulse(1);
    model_capture(2);
    eoc_timing("R5", 0);
    read_chk("R5", 1'b0);
    read_chk("R9", 1'b0);
  endtask

  task automatic t_retrig;
    load_samples(3);
    trig_pulse(2);
    model_capture(3);
    tick(5);
    conv_trig = 1'b0;
    tick(1);
    load_samples(4);
    conv_trig = 1'b1;
    tick(1);
    eoc_timing("R8", 7);
    read_chk("R8", 1'b0);
  endtask

  task automatic t_ignored_strobes;
    write_cfg(4'b0100, 1'b1);  // not selected: format stays offset
    cs_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      rd_n = 1'b0; tick(1); rd_n = 1'b1; tick(1);
    end
    read_chk("R2", 1'b0);
    read_chk("R9", 1'b0);
  endtask

  task automatic t_hiz;
    cs_n = 1'b1; rd_n = 1'b0; tb_drv = 16'hA5C3; tb_drv_en = 1'b1;
    tick(1);
    chk("R10", "bus with cs high", data_io, 16'hA5C3);
    rd_n = 1'b1;
    tick(1);
    cs_n = 1'b0; tb_drv = 16'h3C5A;
    tick(1);
    chk("R10", "bus with rd high", data_io, 16'h3C5A);
    cs_n = 1'b1; tb_drv_en = 1'b0;
    tick(1);
    read_chk("R10", 1'b0);  // pointer untouched by the above
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; conv_trig = 1'b1;
    tb_drv = '0; tb_drv_en = 1'b0; sample_in = '0;
    exp_ptr = 0; exp_fmt = 1'b0;
    for (int ch = 0; ch < NCH; ch++) exp_bank[ch] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_mode0_conv();
    t_format();
    t_short_mode0();
    t_mode1();
    t_retrig();
    t_ignored_strobes();
    t_hiz();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

endmodule